// File: doc/BRIEF.md
# Multicycle Shared-Memory CPU Datapath

This block is the datapath of a small 32-bit load/store processor that spends several clock cycles on each instruction. It covers the ALU operations AND, OR, ADD, SUB and SLT, word load and store, branch-on-equal and jump. Instruction fetch and data access share a single word-array memory. A single ALU performs every computation: PC+4, the branch target, the EPC value, data addresses and register arithmetic. A register set (instruction, memory data, two operand latches and an ALU result latch) carries values from one cycle to the next.

The block contains no sequencing of its own. An external controller drives every strobe and select code each cycle. The datapath returns the current opcode together with the ALU zero and signed-overflow flags, and the controller uses these to choose its next step. A memory image port writes words into the memory so that programs and data can be placed before and during a run. PC, EPC, Cause, the memory read bus and the live ALU result are visible as outputs.

Top module: `mc_datapath`

## Requirements
- R1: While reset is held and after it is released, PC, EPC, Cause and the instruction register are zero, so `opcode` reads 0.
- R2: The memory word index is bits [7:2] of the address. The address is PC when `iord`=0 and the ALU result latch when `iord`=1. `mem_data` carries the addressed word while `mem_read`=1 and is zero otherwise.
- R3: The instruction register loads `mem_data` only on a clock where `ir_write`=1. When `ir_write`=0 it holds its value even if memory is being read.
- R4: ALU operand A is PC when `alu_src_a`=0 and the A latch when it is 1. Operand B is selected by `alu_src_b`: 00 = B latch, 01 = 4, 10 = sign-extended IR[15:0], 11 = that value shifted left by 2.
- R5: `alu_op` 00 adds and 01 subtracts. With 10 the operation comes from IR[5:0]: 0x20 add, 0x22 sub, 0x24 and, 0x25 or, 0x2A set-less-than, and any other code adds. `alu_result` shows the result in the same cycle, and `zero` is 1 exactly when the result is 0.
- R6: Set-less-than compares the two operands as signed values and gives 1 or 0.
- R7: `overflow` is 1 only for an add or subtract whose signed result does not fit in 32 bits. It is never set by and, or or set-less-than.
- R8: On a PC write the new value is selected by `pc_source`: 00 = live ALU result, 01 = ALU result latch, 10 = {PC[31:28], IR[25:0], 00}, 11 = 0x8000_0180.
- R9: PC changes only when `pc_write`=1, or when `pc_write_cond`=1 and `zero`=1 in that cycle.
- R10: The A and B latches load registers IR[25:21] and IR[20:16] on every clock. A register write goes to IR[15:11] when `reg_dst`=1 and to IR[20:16] otherwise. The written data is the memory data latch when `mem_to_reg`=1 and the ALU result latch otherwise. The write is visible from the next cycle.
- R11: Register 0 always reads as zero and ignores writes.
- R12: `epc_write` loads EPC from the live ALU result. `cause_write` loads Cause with `int_cause` zero-extended to 32 bits, where 0 means undefined instruction and 1 means arithmetic overflow. Both registers hold their values otherwise.
- R13: `mem_write` stores the B latch into the word at the current address at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_write | input | 1 | Unconditional PC write |
| pc_write_cond | input | 1 | PC write when the zero flag is set |
| iord | input | 1 | Memory address select: 0 PC, 1 ALU result latch |
| mem_read | input | 1 | Memory read enable |
| mem_write | input | 1 | Memory write enable |
| ir_write | input | 1 | Instruction register load |
| reg_dst | input | 1 | Register write address select |
| mem_to_reg | input | 1 | Register write data select |
| reg_write | input | 1 | Register file write enable |
| alu_src_a | input | 1 | ALU operand A select |
| alu_src_b | input | 2 | ALU operand B select |
| alu_op | input | 2 | ALU operation class |
| pc_source | input | 2 | Next PC select |
| epc_write | input | 1 | EPC load |
| cause_write | input | 1 | Cause load |
| int_cause | input | 1 | Cause code to load |
| img_we | input | 1 | Memory image write enable |
| img_addr | input | 6 | Memory image word index |
| img_wdata | input | 32 | Memory image write data |
| opcode | output | 6 | IR[31:26] |
| zero | output | 1 | ALU result is zero |
| overflow | output | 1 | Signed add/sub overflow |
| pc | output | 32 | Program counter |
| epc | output | 32 | Exception PC |
| cause | output | 32 | Exception cause |
| mem_data | output | 32 | Memory read data |
| alu_result | output | 32 | Live ALU result |

## Verification
During exception entry the shared ALU computes PC-4 for EPC in the same cycle that PC itself is overwritten with the handler address and Cause is written. The bench provokes this after an overflowing add, which gives cause 1, and after an undefined opcode, which gives cause 0. It then checks that EPC holds the PC from before the edge minus 4, and that PC equals the handler address. The same clash appears when a taken branch compares A and B in the ALU while PC loads from the ALU result latch. The bench checks that the target computed during decode is the value PC receives, and that an unequal pair leaves PC unchanged.

// File: rtl/mc_datapath.sv
module mc_datapath #(
  parameter int          MEM_WORDS  = 64,
  parameter logic [31:0] HANDLER_PC = 32'h8000_0180
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pc_write,
  input  logic        pc_write_cond,
  input  logic        iord,
  input  logic        mem_read,
  input  logic        mem_write,
  input  logic        ir_write,
  input  logic        reg_dst,
  input  logic        mem_to_reg,
  input  logic        reg_write,
  input  logic        alu_src_a,
  input  logic [1:0]  alu_src_b,
  input  logic [1:0]  alu_op,
  input  logic [1:0]  pc_source,
  input  logic        epc_write,
  input  logic        cause_write,
  input  logic        int_cause,
  input  logic        img_we,
  input  logic [$clog2(MEM_WORDS)-1:0] img_addr,
  input  logic [31:0] img_wdata,
  output logic [5:0]  opcode,
  output logic        zero,
  output logic        overflow,
  output logic [31:0] pc,
  output logic [31:0] epc,
  output logic [31:0] cause,
  output logic [31:0] mem_data,
  output logic [31:0] alu_result
);
  localparam int IDX_W = $clog2(MEM_WORDS);

  typedef enum logic [2:0] {K_ADD, K_SUB, K_AND, K_OR, K_SLT} alu_kind_e;

  logic [31:0] pc_q, ir_q, mdr_q, a_q, b_q, alu_out_q, epc_q, cause_q;
  logic [31:0] mem [MEM_WORDS];
  logic [31:0] rf [32];

  logic [31:0] addr, sext, opa, opb, bb, pc_next, wdata;
  logic [IDX_W-1:0] widx;
  logic [4:0]  waddr;
  logic [32:0] sum;
  logic        do_sub, cmsb, vflag, pc_en;
  alu_kind_e   kind;

  assign addr     = iord ? alu_out_q : pc_q;
  assign widx     = IDX_W'(addr >> 2);
  assign mem_data = mem_read ? mem[widx] : '0;
  assign sext     = {{16{ir_q[15]}}, ir_q[15:0]};
  assign opa      = alu_src_a ? a_q : pc_q;

  always_comb begin
    unique case (alu_src_b)
      2'b00:   opb = b_q;
      2'b01:   opb = 32'd4;
      2'b10:   opb = sext;
      default: opb = sext << 2;
    endcase
  end

  always_comb begin
    kind = K_ADD;
    unique case (alu_op)
      2'b01: kind = K_SUB;
      2'b10: begin
        unique case (ir_q[5:0])
          6'h22:   kind = K_SUB;
          6'h24:   kind = K_AND;
          6'h25:   kind = K_OR;
          6'h2A:   kind = K_SLT;
          default: kind = K_ADD;
        endcase
      end
      default: kind = K_ADD;
    endcase
  end

  assign do_sub = (kind == K_SUB) || (kind == K_SLT);
  assign bb     = do_sub ? ~opb : opb;
  assign sum    = {1'b0, opa} + {1'b0, bb} + {32'b0, do_sub};
  assign cmsb   = opa[31] ^ bb[31] ^ sum[31];
  assign vflag  = sum[32] ^ cmsb;

  always_comb begin
    unique case (kind)
      K_AND:   alu_result = opa & opb;
      K_OR:    alu_result = opa | opb;
      K_SLT:   alu_result = {31'b0, sum[31] ^ vflag};
      default: alu_result = sum[31:0];
    endcase
  end

  assign overflow = ((kind == K_ADD) || (kind == K_SUB)) && vflag;
  assign zero     = (alu_result == '0);

  always_comb begin
    unique case (pc_source)
      2'b00:   pc_next = alu_result;
      2'b01:   pc_next = alu_out_q;
      2'b10:   pc_next = {pc_q[31:28], ir_q[25:0], 2'b00};
      default: pc_next = HANDLER_PC;
    endcase
  end

  assign pc_en = pc_write || (pc_write_cond && zero);
  assign waddr = reg_dst ? ir_q[15:11] : ir_q[20:16];
  assign wdata = mem_to_reg ? mdr_q : alu_out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q      <= '0;
      ir_q      <= '0;
      mdr_q     <= '0;
      a_q       <= '0;
      b_q       <= '0;
      alu_out_q <= '0;
      epc_q     <= '0;
      cause_q   <= '0;
    end else begin
      if (pc_en)       pc_q    <= pc_next;
      if (ir_write)    ir_q    <= mem_data;
      if (epc_write)   epc_q   <= alu_result;
      if (cause_write) cause_q <= {31'b0, int_cause};
      mdr_q     <= mem_data;
      a_q       <= rf[ir_q[25:21]];
      b_q       <= rf[ir_q[20:16]];
      alu_out_q <= alu_result;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= '0;
    end else if (reg_write && waddr != 5'd0) begin
      rf[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (img_we)         mem[img_addr] <= img_wdata;
    else if (mem_write) mem[widx]     <= b_q;
  end

  assign opcode = ir_q[31:26];
  assign pc     = pc_q;
  assign epc    = epc_q;
  assign cause  = cause_q;
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk #(
  parameter logic [31:0] HANDLER_PC = 32'h8000_0180
) (
  input logic        clk,
  input logic        rst_n,
  input logic        pc_write,
  input logic        pc_write_cond,
  input logic        ir_write,
  input logic        epc_write,
  input logic        cause_write,
  input logic        int_cause,
  input logic [1:0]  pc_source,
  input logic [1:0]  alu_op,
  input logic [5:0]  ir_funct,
  input logic [5:0]  opcode,
  input logic        zero,
  input logic        overflow,
  input logic [31:0] pc,
  input logic [31:0] epc,
  input logic [31:0] cause
);
  // R9
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_write && !pc_write_cond) |=> $stable(pc));

  // R9
  beq_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_write && pc_write_cond && !zero) |=> $stable(pc));

  // R8
  handler_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_write && pc_source == 2'b11) |=> (pc == HANDLER_PC));

  // R3
  ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_write |=> $stable(opcode));

  // R12
  epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !epc_write |=> $stable(epc));

  // R12
  cause_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cause_write |=> (cause == {31'b0, $past(int_cause)}));

  // R12
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_write |=> $stable(cause));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == 2'b10 && (ir_funct == 6'h24 || ir_funct == 6'h25 || ir_funct == 6'h2A))
      |-> !overflow);
endmodule

bind mc_datapath mc_datapath_chk #(.HANDLER_PC(HANDLER_PC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc_write(pc_write), .pc_write_cond(pc_write_cond),
  .ir_write(ir_write), .epc_write(epc_write), .cause_write(cause_write),
  .int_cause(int_cause), .pc_source(pc_source), .alu_op(alu_op),
  .ir_funct(ir_q[5:0]), .opcode(opcode), .zero(zero), .overflow(overflow),
  .pc(pc), .epc(epc), .cause(cause)
);

// File: tb/test_mc_datapath.sv
`timescale 1ns/100ps
module test_mc_datapath;
  localparam logic [31:0] HANDLER = 32'h8000_0180;

  logic clk = 0, rst_n = 0;
  logic pc_write, pc_write_cond, iord, mem_read, mem_write, ir_write;
  logic reg_dst, mem_to_reg, reg_write, alu_src_a, epc_write, cause_write, int_cause;
  logic [1:0] alu_src_b, alu_op, pc_source;
  logic img_we;
  logic [5:0] img_addr;
  logic [31:0] img_wdata;
  logic [5:0] opcode;
  logic zero, overflow;
  logic [31:0] pc, epc, cause, mem_data, alu_result;

  always #2.5 clk = ~clk;

  mc_datapath i_mc_datapath (
    .clk(clk), .rst_n(rst_n), .pc_write(pc_write), .pc_write_cond(pc_write_cond),
    .iord(iord), .mem_read(mem_read), .mem_write(mem_write), .ir_write(ir_write),
    .reg_dst(reg_dst), .mem_to_reg(mem_to_reg), .reg_write(reg_write),
    .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_op(alu_op),
    .pc_source(pc_source), .epc_write(epc_write), .cause_write(cause_write),
    .int_cause(int_cause), .img_we(img_we), .img_addr(img_addr),
    .img_wdata(img_wdata), .opcode(opcode), .zero(zero), .overflow(overflow),
    .pc(pc), .epc(epc), .cause(cause), .mem_data(mem_data), .alu_result(alu_result)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] bpc, bir, ba, bb, bout, bmdr, bepc;
  logic [31:0] brf [32];
  logic [31:0] bmem [64];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    {pc_write, pc_write_cond, iord, mem_read, mem_write, ir_write} = '0;
    {reg_dst, mem_to_reg, reg_write, alu_src_a, epc_write, cause_write, int_cause} = '0;
    alu_src_b = 2'b00; alu_op = 2'b00; pc_source = 2'b00; img_we = 0;
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    idle();
  endtask

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  // returns {overflow, result}
  function automatic logic [32:0] alu_m(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] y;
    case (f)
      6'h22: begin y = a - b; return {(a[31] != b[31]) && (y[31] != a[31]), y}; end
      6'h24: return {1'b0, a & b};
      6'h25: return {1'b0, a | b};
      6'h2A: return {1'b0, 31'b0, ($signed(a) < $signed(b))};
      default: begin y = a + b; return {(a[31] == b[31]) && (y[31] != a[31]), y}; end
    endcase
  endfunction

  task automatic img_load(input logic [5:0] idx, input logic [31:0] w);
    img_we = 1; img_addr = idx; img_wdata = w;
    cyc();
    bmem[idx] = w;
  endtask

  task automatic fetch(input logic [31:0] instr);
    img_load(bpc[7:2], instr);
    mem_read = 1; ir_write = 1; alu_src_b = 2'b01; pc_write = 1;
    #1;
    chk(mem_data == instr, "R2 fetch data", mem_data, instr);
    chk(alu_result == bpc + 4, "R4 pc+4", alu_result, bpc + 4);
    cyc();
    bpc = bpc + 4; bir = instr;
    chk(pc == bpc, "R8 pc after fetch", pc, bpc);
    chk(opcode == instr[31:26], "R3 opcode", {26'b0, opcode}, {26'b0, instr[31:26]});
  endtask

  task automatic decode();
    logic [31:0] e;
    alu_src_b = 2'b11;
    #1;
    e = bpc + (sx(bir[15:0]) << 2);
    chk(alu_result == e, "R4 branch target", alu_result, e);
    cyc();
    ba = brf[bir[25:21]]; bb = brf[bir[20:16]]; bout = e;
  endtask

  task automatic jump_to(input logic [25:0] tgt);
    fetch({6'h02, tgt}); decode();
    pc_write = 1; pc_source = 2'b10;
    cyc();
    bpc = {bpc[31:28], tgt, 2'b00};
    chk(pc == bpc, "R8 jump", pc, bpc);
  endtask

  task automatic guard();
    if (bpc[7:2] >= 6'd40) jump_to(26'd0);
  endtask

  task automatic take_exc(input logic c);
    cause_write = 1; int_cause = c; alu_src_b = 2'b01; alu_op = 2'b01;
    epc_write = 1; pc_write = 1; pc_source = 2'b11;
    #1;
    chk(alu_result == bpc - 4, "R12 pc-4", alu_result, bpc - 4);
    cyc();
    bepc = bpc - 4; bpc = HANDLER;
    chk(epc == bepc, "R12 epc", epc, bepc);
    chk(cause == {31'b0, c}, "R12 cause", cause, {31'b0, c});
    chk(pc == HANDLER, "R8 handler", pc, HANDLER);
  endtask

  task automatic run_r(input logic [4:0] rs, rt, rd, input logic [5:0] f, input bit exc_on_ovf);
    logic [32:0] m;
    guard();
    fetch({6'h00, rs, rt, rd, 5'h00, f}); decode();
    alu_src_a = 1; alu_op = 2'b10;
    #1;
    m = alu_m(f, ba, bb);
    chk(alu_result == m[31:0], (f == 6'h2A) ? "R6 slt" : "R5 alu", alu_result, m[31:0]);
    chk(overflow == m[32], "R7 overflow", {31'b0, overflow}, {31'b0, m[32]});
    chk(zero == (m[31:0] == 0), "R5 zero", {31'b0, zero}, {31'b0, m[31:0] == 0});
    cyc();
    bout = m[31:0];
    reg_dst = 1; reg_write = 1;
    cyc();
    if (rd != 0) brf[rd] = bout;
    if (m[32] && exc_on_ovf) take_exc(1'b1);
  endtask

  task automatic run_lw(input logic [4:0] rs, rt, input logic [15:0] imm);
    logic [31:0] e;
    guard();
    fetch({6'h23, rs, rt, imm}); decode();
    alu_src_a = 1; alu_src_b = 2'b10;
    #1;
    e = ba + sx(imm);
    chk(alu_result == e, "R4 address", alu_result, e);
    cyc();
    bout = e;
    iord = 1; mem_read = 1;
    #1;
    chk(mem_data == bmem[bout[7:2]], "R2 load data", mem_data, bmem[bout[7:2]]);
    cyc();
    bmdr = bmem[bout[7:2]];
    mem_to_reg = 1; reg_write = 1;
    cyc();
    if (rt != 0) brf[rt] = bmdr;
  endtask

  task automatic run_sw(input logic [4:0] rs, rt, input logic [15:0] imm);
    guard();
    fetch({6'h2B, rs, rt, imm}); decode();
    alu_src_a = 1; alu_src_b = 2'b10;
    cyc();
    bout = ba + sx(imm);
    iord = 1; mem_write = 1;
    cyc();
    bmem[bout[7:2]] = bb;
  endtask

  task automatic run_beq(input logic [4:0] rs, rt, input logic [5:0] tgt);
    logic [15:0] off;
    guard();
    off = 16'(int'(tgt) - int'(bpc[7:2]) - 1);
    fetch({6'h04, rs, rt, off}); decode();
    alu_src_a = 1; alu_op = 2'b01; pc_write_cond = 1; pc_source = 2'b01;
    #1;
    chk(zero == (ba == bb), "R9 compare", {31'b0, zero}, {31'b0, ba == bb});
    cyc();
    if (ba == bb) bpc = bout;
    chk(pc == bpc, "R9 branch pc", pc, bpc);
  endtask

  task automatic run_undef();
    guard();
    fetch({6'h3F, 26'h155_5555}); decode();
    take_exc(1'b0);
  endtask

  task automatic setreg(input logic [4:0] r, input logic [31:0] v);
    img_load(6'd63, v);
    run_lw(5'd0, r, 16'h00FC);
  endtask

  task automatic chkreg(input logic [4:0] r, input logic [31:0] v, input string req);
    run_r(r, 5'd0, 5'd0, 6'h25, 0);
    chk(bout == v, req, bout, v);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", checks, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    idle();
    img_addr = '0; img_wdata = '0;
    for (int i = 0; i < 32; i++) brf[i] = 0;
    for (int i = 0; i < 64; i++) bmem[i] = 0;
    bpc = 0; bir = 0; bepc = 0;
    repeat (2) @(posedge clk);
    #1;
    chk(pc == 0 && epc == 0 && cause == 0, "R1 reset pc/epc/cause", pc | epc | cause, 0);
    chk(opcode == 0, "R1 reset opcode", {26'b0, opcode}, 0);
    rst_n = 1;
    cyc();
    chk(pc == 0, "R1 pc after release", pc, 0);
    #1;
    chk(mem_data == 0, "R2 idle read bus", mem_data, 0);

    for (int i = 48; i < 63; i++) img_load(6'(i), $urandom);

    // directed arithmetic corners
    setreg(5'd1, 32'h7FFF_FFFF);
    setreg(5'd2, 32'h0000_0001);
    setreg(5'd4, 32'h8000_0000);
    run_r(5'd1, 5'd2, 5'd3, 6'h20, 0);
    chk(overflow == 0, "R7 flag drops after add", {31'b0, overflow}, 0);
    run_r(5'd4, 5'd2, 5'd5, 6'h22, 0);
    run_r(5'd4, 5'd2, 5'd6, 6'h2A, 0);
    chk(bout == 1, "R6 negative less than positive", bout, 1);
    run_r(5'd2, 5'd4, 5'd6, 6'h2A, 0);
    chk(bout == 0, "R6 positive not less", bout, 0);
    run_r(5'd1, 5'd4, 5'd7, 6'h24, 0);
    run_r(5'd1, 5'd4, 5'd7, 6'h25, 0);
    chk(bout == 32'hFFFF_FFFF, "R5 or", bout, 32'hFFFF_FFFF);
    run_r(5'd1, 5'd4, 5'd7, 6'h3F, 0);
    chk(bout == 32'hFFFF_FFFF, "R5 unknown funct adds", bout, 32'hFFFF_FFFF);

    // register 0
    run_r(5'd1, 5'd2, 5'd0, 6'h20, 0);
    run_lw(5'd0, 5'd0, 16'h00C0);
    chkreg(5'd0, 0, "R11 r0 reads zero");

    // register write then read
    run_r(5'd2, 5'd2, 5'd9, 6'h20, 0);
    chkreg(5'd9, 2, "R10 rd write visible");

    // store then load back
    setreg(5'd10, 32'hCAFE_F00D);
    run_sw(5'd0, 5'd10, 16'h00D0);
    run_lw(5'd0, 5'd11, 16'h00D0);
    chk(bmdr == 32'hCAFE_F00D, "R13 stored word", bmdr, 32'hCAFE_F00D);
    chkreg(5'd11, 32'hCAFE_F00D, "R13 load after store");

    // IR hold while memory is read
    guard();
    fetch({6'h00, 5'd2, 5'd2, 5'd12, 5'd0, 6'h20});
    img_load(bpc[7:2], 32'hFC00_0000);
    mem_read = 1;
    cyc();
    chk(opcode == 6'h00, "R3 ir holds", {26'b0, opcode}, 0);
    decode();
    alu_src_a = 1; alu_op = 2'b10;
    #1;
    chk(alu_result == 2, "R3 held funct used", alu_result, 2);
    cyc();

    // branches, jump, exceptions
    run_beq(5'd1, 5'd1, 6'd3);
    chk(pc[7:2] == 3, "R9 taken target", {26'b0, pc[7:2]}, 3);
    run_beq(5'd1, 5'd2, 6'd20);
    jump_to(26'd30);
    run_r(5'd1, 5'd2, 5'd3, 6'h20, 1);
    chk(epc == bepc && pc == HANDLER, "R12 overflow entry", epc, bepc);
    run_undef();
    chk(cause == 0, "R12 undefined cause", cause, 0);

    // constrained random
    for (int r = 1; r < 8; r++) setreg(5'(r), $urandom);
    for (int n = 0; n < 250; n++) begin
      logic [2:0] k;
      logic [5:0] fsel;
      k = 3'($urandom_range(0, 6));
      case ($urandom_range(0, 4))
        0: fsel = 6'h20; 1: fsel = 6'h22; 2: fsel = 6'h24; 3: fsel = 6'h25; default: fsel = 6'h2A;
      endcase
      case (k)
        0: run_lw(5'd0, 5'($urandom_range(0, 7)), 16'(32'hC0 + 4 * $urandom_range(0, 15)));
        1: run_sw(5'd0, 5'($urandom_range(0, 7)), 16'(32'hC0 + 4 * $urandom_range(0, 14)));
        2: run_beq(5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)), 6'($urandom_range(0, 39)));
        3: jump_to(26'($urandom_range(0, 39)));
        4: if ($urandom_range(0, 3) == 0) run_undef();
           else run_r(5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)), fsel, 1);
        default: run_r(5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)), fsel, 1);
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule